// File: doc/BRIEF.md
# Virtualized Identification Register Access Unit

This block holds the guest-visible copy of the processor identification word and decides the outcome of every system-register access aimed at that copy or at the physical identification register. The outcome depends on the current privilege level (0 to 3), the nested-virtualization control bits, the fine-grained read-trap controls and a few static configuration inputs. Each access ends in exactly one outcome: undefined instruction, trap to a higher level with a syndrome class, redirect to memory at a fixed offset, or a direct completion that carries read data.

A request is presented for one cycle with `req_valid`. The control sequencer has two states. `ST_IDLE` is the resting state. The transition `IDLE_TO_RESP` is taken on any clock edge where `req_valid` is high. In `ST_RESP` the registered response is presented for exactly one cycle. From there, `RESP_TO_IDLE` is taken when no new request arrives, and `RESP_TO_RESP` is taken when a new request arrives back to back. The guest copy is written at the same edge that captures the response. A read issued one cycle after a write therefore already sees the new value. The guest copy resets to the physical identification value set by a parameter. The memory access and the exception entry belong to the neighbouring logic.

Top module: `vid_access_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each clock edge that samples `req_valid` high, and low in the cycle after an edge that samples it low.
- R2: While `rsp_valid` is high, exactly one of `rsp_undef`, `rsp_trap`, `rsp_redir` and `rsp_done` is high. While it is low, all four are low. `rsp_trap_el` and `rsp_trap_class` are zero unless `rsp_trap` is high. `rsp_redir_off` and `rsp_redir_write` are zero unless `rsp_redir` is high.
- R3: After reset all outputs are zero, and the guest copy holds `PHYS_ID`. A level-2 read of the guest copy returns `PHYS_ID`.
- R4: The guest copy is selected by op0=3, op1=4, CRn=0, CRm=0, op2=0. The physical register is selected by the same fields with op1=0. Any other encoding is undefined, and so is a write to the physical register.
- R5: Any access to the guest copy at level 0 is undefined.
- R6: At level 1, an access to the guest copy behaves as follows. With nv bits 0 and 2 both set, it is redirected to offset 0x088, and `rsp_redir_write` equals `req_write`. With nv bit 0 set and bit 2 clear, it traps to level 2 (`rsp_trap_el`=2) with class 0x18. With nv bit 0 clear, it is undefined. Nv bit 1 has no effect.
- R7: At level 2, the guest copy is read and written directly. A write keeps `req_wdata[31:0]` and discards bits 63:32.
- R8: At level 3 with `el2_impl`=0, a read of the guest copy returns `PHYS_ID` and a write completes with no effect on the stored value. With `el2_impl`=1, access is direct as at level 2.
- R9: A read of the physical register returns the guest copy at level 1 when level 2 is implemented and enabled. It returns `PHYS_ID` at level 1 otherwise, and always at levels 2 and 3.
- R10: At level 1, a physical read traps to level 2 with class 0x18 when all four of these conditions hold: level 2 is implemented and enabled, `fgt_impl` is set, `el3_present` is clear or `el3_fgt_en` is set, and `fgt_id_rd_trap` is set.
- R11: At level 0, a physical read traps with class 0x18 when `idst_impl` is set. The target is level 2 if level 2 is implemented and enabled and `tge` is set, and level 1 otherwise. Without `idst_impl` the read is undefined.
- R12: `rsp_rdata` is zero except on a completed read, and bits 63:32 of `rsp_rdata` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level |
| nv_bits | input | 3 | Nested-virtualization controls |
| el2_impl | input | 1 | Level 2 is implemented |
| el2_enabled | input | 1 | Level 2 is enabled in the current security state |
| fgt_impl | input | 1 | Fine-grained traps are implemented |
| el3_present | input | 1 | Level 3 is implemented |
| el3_fgt_en | input | 1 | Level 3 allows fine-grained traps |
| fgt_id_rd_trap | input | 1 | Per-register fine-grained read trap for the physical register |
| idst_impl | input | 1 | Identification-space trapping is implemented |
| tge | input | 1 | Route general exceptions to level 2 |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_trap | output | 1 | Trap |
| rsp_trap_el | output | 2 | Trap target level |
| rsp_trap_class | output | 6 | Trap syndrome class |
| rsp_redir | output | 1 | Memory redirect request |
| rsp_redir_off | output | 12 | Memory redirect offset |
| rsp_redir_write | output | 1 | Redirect is a write |
| rsp_done | output | 1 | Access completed directly |

## Verification
The state write and the response capture fall on the same edge. The case that matters is a direct write at level 2 or level 3, followed at the next request by a read of the guest copy or a level-1 physical read with level 2 enabled. That read must see the newly written value, not the old one. The sweep provokes this naturally, because it covers every level, nv pattern, direction and configuration while a bench-side model of the stored value tracks each completed write. Each read is judged against that model, together with the one-hot outcome and the field zeroing.

// File: rtl/vid_pkg.sv
package vid_pkg;
    typedef enum logic [1:0] {
        ACT_UNDEF = 2'd0,
        ACT_TRAP  = 2'd1,
        ACT_REDIR = 2'd2,
        ACT_DONE  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_VIRT = 2'd1,
        SRC_PHYS = 2'd2
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

    typedef struct packed {
        act_e       act;
        src_e       src;
        logic       vwr;
        logic [1:0] trap_el;
    } dec_t;
endpackage

// File: rtl/vid_decode.sv
module vid_decode
    import vid_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  logic       is_write,
    input  logic [1:0] lvl,
    input  logic [2:0] nv,
    input  logic       el2_impl,
    input  logic       el2_enabled,
    input  logic       fgt_impl,
    input  logic       el3_present,
    input  logic       el3_fgt_en,
    input  logic       fgt_rd,
    input  logic       idst_impl,
    input  logic       tge,
    output dec_t       dec
);
    logic common_hit, hit_virt, hit_phys, el2_on, fg_trap, nv_mid_unused;

    assign common_hit    = (op0 == 2'b11) && (crn == 4'd0) && (crm == 4'd0) && (op2 == 3'd0);
    assign hit_virt      = common_hit && (op1 == 3'b100);
    assign hit_phys      = common_hit && (op1 == 3'b000);
    assign el2_on        = el2_impl && el2_enabled;
    assign fg_trap       = el2_on && fgt_impl && (!el3_present || el3_fgt_en) && fgt_rd;
    assign nv_mid_unused = nv[1];

    always_comb begin
        dec = '{act: ACT_UNDEF, src: SRC_NONE, vwr: 1'b0, trap_el: 2'd0};
        if (hit_virt) begin
            unique case (lvl)
                2'd0: dec.act = ACT_UNDEF;
                2'd1: begin
                    if (nv[0] && nv[2]) begin
                        dec.act = ACT_REDIR;
                    end else if (nv[0]) begin
                        dec.act     = ACT_TRAP;
                        dec.trap_el = 2'd2;
                    end
                end
                2'd2: begin
                    dec.act = ACT_DONE;
                    if (is_write) dec.vwr = 1'b1;
                    else          dec.src = SRC_VIRT;
                end
                2'd3: begin
                    dec.act = ACT_DONE;
                    if (is_write) dec.vwr = el2_impl;
                    else          dec.src = el2_impl ? SRC_VIRT : SRC_PHYS;
                end
            endcase
        end else if (hit_phys && !is_write) begin
            unique case (lvl)
                2'd0: begin
                    if (idst_impl) begin
                        dec.act     = ACT_TRAP;
                        dec.trap_el = (el2_on && tge) ? 2'd2 : 2'd1;
                    end
                end
                2'd1: begin
                    if (fg_trap) begin
                        dec.act     = ACT_TRAP;
                        dec.trap_el = 2'd2;
                    end else begin
                        dec.act = ACT_DONE;
                        dec.src = el2_on ? SRC_VIRT : SRC_PHYS;
                    end
                end
                2'd2, 2'd3: begin
                    dec.act = ACT_DONE;
                    dec.src = SRC_PHYS;
                end
            endcase
        end
    end
endmodule

// File: rtl/vid_store.sv
module vid_store #(
    parameter int          ID_W    = 32,
    parameter logic [31:0] PHYS_ID = 32'h5A1F_C0D3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [ID_W-1:0] wdata,
    output logic [ID_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  value <= PHYS_ID[ID_W-1:0];
        else if (we) value <= wdata;
    end
endmodule

// File: rtl/vid_access_unit.sv
module vid_access_unit
    import vid_pkg::*;
#(
    parameter int          XLEN       = 64,
    parameter int          ID_W       = 32,
    parameter int          OFF_W      = 12,
    parameter int          EC_W       = 6,
    parameter logic [31:0] PHYS_ID    = 32'h5A1F_C0D3,
    parameter logic [11:0] NV_OFFSET  = 12'h088,
    parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic             req_write,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic [1:0]       cur_el,
    input  logic [2:0]       nv_bits,
    input  logic             el2_impl,
    input  logic             el2_enabled,
    input  logic             fgt_impl,
    input  logic             el3_present,
    input  logic             el3_fgt_en,
    input  logic             fgt_id_rd_trap,
    input  logic             idst_impl,
    input  logic             tge,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic             rsp_undef,
    output logic             rsp_trap,
    output logic [1:0]       rsp_trap_el,
    output logic [EC_W-1:0]  rsp_trap_class,
    output logic             rsp_redir,
    output logic [OFF_W-1:0] rsp_redir_off,
    output logic             rsp_redir_write,
    output logic             rsp_done
);
    localparam int HI_W = XLEN - ID_W;

    dec_t            dec;
    fsm_e            state_q, state_d;
    logic [ID_W-1:0] vreg;
    logic            store_we;
    logic            wdata_unused;
    logic [ID_W-1:0] rd_word;

    assign wdata_unused = ^req_wdata[XLEN-1:ID_W];

    vid_decode u_decode (
        .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
        .is_write(req_write), .lvl(cur_el), .nv(nv_bits),
        .el2_impl(el2_impl), .el2_enabled(el2_enabled), .fgt_impl(fgt_impl),
        .el3_present(el3_present), .el3_fgt_en(el3_fgt_en), .fgt_rd(fgt_id_rd_trap),
        .idst_impl(idst_impl), .tge(tge), .dec(dec)
    );

    assign store_we = req_valid && (dec.act == ACT_DONE) && dec.vwr;

    vid_store #(.ID_W(ID_W), .PHYS_ID(PHYS_ID)) u_store (
        .clk(clk), .rst_n(rst_n), .we(store_we),
        .wdata(req_wdata[ID_W-1:0]), .value(vreg)
    );

    always_comb begin
        unique case (dec.src)
            SRC_VIRT: rd_word = vreg;
            SRC_PHYS: rd_word = PHYS_ID[ID_W-1:0];
            default:  rd_word = '0;
        endcase
    end

    // Sequencer: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata       <= '0;
            rsp_undef       <= 1'b0;
            rsp_trap        <= 1'b0;
            rsp_trap_el     <= '0;
            rsp_trap_class  <= '0;
            rsp_redir       <= 1'b0;
            rsp_redir_off   <= '0;
            rsp_redir_write <= 1'b0;
            rsp_done        <= 1'b0;
        end else if (req_valid) begin
            rsp_rdata       <= {{HI_W{1'b0}}, rd_word};
            rsp_undef       <= (dec.act == ACT_UNDEF);
            rsp_trap        <= (dec.act == ACT_TRAP);
            rsp_trap_el     <= (dec.act == ACT_TRAP) ? dec.trap_el : 2'd0;
            rsp_trap_class  <= (dec.act == ACT_TRAP) ? TRAP_CLASS[EC_W-1:0] : '0;
            rsp_redir       <= (dec.act == ACT_REDIR);
            rsp_redir_off   <= (dec.act == ACT_REDIR) ? NV_OFFSET[OFF_W-1:0] : '0;
            rsp_redir_write <= (dec.act == ACT_REDIR) && req_write;
            rsp_done        <= (dec.act == ACT_DONE);
        end else begin
            rsp_rdata       <= '0;
            rsp_undef       <= 1'b0;
            rsp_trap        <= 1'b0;
            rsp_trap_el     <= '0;
            rsp_trap_class  <= '0;
            rsp_redir       <= 1'b0;
            rsp_redir_off   <= '0;
            rsp_redir_write <= 1'b0;
            rsp_done        <= 1'b0;
        end
    end
endmodule

// File: rtl/vid_access_chk.sv
module vid_access_chk #(
    parameter int          XLEN       = 64,
    parameter int          OFF_W      = 12,
    parameter int          EC_W       = 6,
    parameter logic [11:0] NV_OFFSET  = 12'h088,
    parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op0,
    input logic [2:0]       req_op1,
    input logic [3:0]       req_crn,
    input logic [3:0]       req_crm,
    input logic [2:0]       req_op2,
    input logic [1:0]       cur_el,
    input logic             rsp_valid,
    input logic [XLEN-1:0]  rsp_rdata,
    input logic             rsp_undef,
    input logic             rsp_trap,
    input logic [1:0]       rsp_trap_el,
    input logic [EC_W-1:0]  rsp_trap_class,
    input logic             rsp_redir,
    input logic [OFF_W-1:0] rsp_redir_off,
    input logic             rsp_done
);
    logic virt_sel;
    assign virt_sel = (req_op0 == 2'b11) && (req_op1 == 3'b100) && (req_crn == 4'd0) &&
                      (req_crm == 4'd0) && (req_op2 == 3'd0);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_undef, rsp_trap, rsp_redir, rsp_done}));

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_undef, rsp_trap, rsp_redir, rsp_done} == 4'b0));

    // R5
    el0_virt_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && virt_sel && cur_el == 2'd0) |=> rsp_undef);

    // R6
    redir_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redir |-> (rsp_redir_off == NV_OFFSET[OFF_W-1:0]));

    // R10
    trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_trap_class == TRAP_CLASS[EC_W-1:0] &&
                      (rsp_trap_el == 2'd1 || rsp_trap_el == 2'd2)));

    // R12
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[XLEN-1:32] == '0);
endmodule

bind vid_access_unit vid_access_chk #(
    .XLEN(XLEN), .OFF_W(OFF_W), .EC_W(EC_W),
    .NV_OFFSET(NV_OFFSET), .TRAP_CLASS(TRAP_CLASS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .cur_el(cur_el), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_trap_el(rsp_trap_el),
    .rsp_trap_class(rsp_trap_class), .rsp_redir(rsp_redir),
    .rsp_redir_off(rsp_redir_off), .rsp_done(rsp_done)
);

// File: tb/vid_access_unit_tb_top.sv
module vid_access_unit_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] PHYS       = 32'h5A1F_C0D3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = '0;
    logic [2:0]  nv_bits = '0;
    logic        el2_impl = 0, el2_enabled = 0, fgt_impl = 0, el3_present = 0;
    logic        el3_fgt_en = 0, fgt_id_rd_trap = 0, idst_impl = 0, tge = 0;
    logic        rsp_valid, rsp_undef, rsp_trap, rsp_redir, rsp_redir_write, rsp_done;
    logic [63:0] rsp_rdata;
    logic [1:0]  rsp_trap_el;
    logic [5:0]  rsp_trap_class;
    logic [11:0] rsp_redir_off;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_write(req_write), .req_wdata(req_wdata),
        .cur_el(cur_el), .nv_bits(nv_bits), .el2_impl(el2_impl), .el2_enabled(el2_enabled),
        .fgt_impl(fgt_impl), .el3_present(el3_present), .el3_fgt_en(el3_fgt_en),
        .fgt_id_rd_trap(fgt_id_rd_trap), .idst_impl(idst_impl), .tge(tge),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
        .rsp_trap(rsp_trap), .rsp_trap_el(rsp_trap_el), .rsp_trap_class(rsp_trap_class),
        .rsp_redir(rsp_redir), .rsp_redir_off(rsp_redir_off),
        .rsp_redir_write(rsp_redir_write), .rsp_done(rsp_done)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            if (failures <= 20)
                $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pack_rsp();
        return {39'd0, rsp_valid, rsp_undef, rsp_trap, rsp_redir, rsp_done,
                rsp_trap_el, rsp_trap_class, rsp_redir_off, rsp_redir_write, rsp_rdata};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] mv;
        mv = PHYS;
        repeat (3) @(negedge clk);
        // R3: outputs cleared during and after reset
        check(pack_rsp() == '0, "R3", pack_rsp(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pack_rsp() == '0, "R3", pack_rsp(), '0);
        // R3: level-2 read of the guest copy returns the reset value
        req_op0 = 2'b11; req_op1 = 3'b100; cur_el = 2'd2; req_write = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_done && rsp_rdata == {32'd0, PHYS}, "R3", {64'd0, rsp_rdata}, {96'd0, PHYS});
        @(negedge clk);

        for (int sel = 0; sel < 3; sel++)
        for (int el = 0; el < 4; el++)
        for (int nv = 0; nv < 8; nv++)
        for (int w = 0; w < 2; w++)
        for (int cfg = 0; cfg < 256; cfg++) begin
            logic [31:0] cnt;
            logic [63:0] wd, e_data;
            logic [3:0]  e_flags;
            logic [1:0]  e_tel;
            logic        on, e_wr;
            string       tag;
            logic [127:0] exp_v;
            cnt = 32'(((((sel*4+el)*8+nv)*2+w)*256)+cfg);
            wd  = {~cnt, cnt ^ 32'hA5C3_0F1E};
            on  = cfg[0] && cfg[1];
            e_flags = 4'b1000; e_tel = 2'd0; e_data = '0; e_wr = 1'b0; tag = "R4";
            if (sel == 0) begin
                if (el == 0) begin
                    tag = "R5";
                end else if (el == 1) begin
                    tag = "R6";
                    if (nv[0] && nv[2]) begin e_flags = 4'b0010; e_wr = w[0]; end
                    else if (nv[0]) begin e_flags = 4'b0100; e_tel = 2'd2; end
                end else if (el == 2) begin
                    tag = "R7"; e_flags = 4'b0001;
                    if (w == 0) e_data = {32'd0, mv};
                end else begin
                    tag = "R8"; e_flags = 4'b0001;
                    if (w == 0) e_data = {32'd0, cfg[0] ? mv : PHYS};
                end
            end else if (sel == 1 && w == 0) begin
                if (el == 0) begin
                    tag = "R11";
                    if (cfg[6]) begin e_flags = 4'b0100; e_tel = (on && cfg[7]) ? 2'd2 : 2'd1; end
                end else if (el == 1 && on && cfg[2] && (!cfg[3] || cfg[4]) && cfg[5]) begin
                    tag = "R10"; e_flags = 4'b0100; e_tel = 2'd2;
                end else begin
                    tag = "R9"; e_flags = 4'b0001;
                    e_data = {32'd0, (el == 1 && on) ? mv : PHYS};
                end
            end
            exp_v = {39'd0, 1'b1, e_flags, e_tel, (e_flags[2] ? 6'h18 : 6'h00),
                     (e_flags[1] ? 12'h088 : 12'h000), e_wr, e_data};

            req_op0 = 2'b11; req_crn = 4'd0; req_op2 = 3'd0;
            req_op1 = (sel == 1) ? 3'b000 : 3'b100;
            req_crm = (sel == 2) ? 4'd1 : 4'd0;
            req_write = w[0]; req_wdata = wd; cur_el = 2'(el); nv_bits = 3'(nv);
            {tge, idst_impl, fgt_id_rd_trap, el3_fgt_en, el3_present, fgt_impl,
             el2_enabled, el2_impl} = 8'(cfg);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(pack_rsp() == exp_v, tag, pack_rsp(), exp_v);
            // R2: single outcome flag
            check($countones({rsp_undef, rsp_trap, rsp_redir, rsp_done}) == 1, "R2",
                  pack_rsp(), exp_v);
            // R12: upper read data bits zero
            check(rsp_rdata[63:32] == 32'd0, "R12", {64'd0, rsp_rdata}, '0);
            // model update: direct writes at level 2, or level 3 with level 2 present
            if (sel == 0 && w == 1 && (el == 2 || (el == 3 && cfg[0]))) mv = wd[31:0];
            @(negedge clk);
            // R1: response lasts one cycle
            check(!rsp_valid && pack_rsp() == '0, "R1", pack_rsp(), '0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule